// File: doc/BRIEF.md
# Receive FIFO with Idle-Timeout Data-Ready Flag

This block sits behind an asynchronous serial deserializer. It buffers received bytes in a first-in-first-out queue. The CPU or a DMA engine drains the queue. Whenever the fill level reaches the programmed trigger level, the block raises a full-trigger request.

When only a few bytes remain below the trigger level and the line then goes quiet, no trigger request will ever come for them. The block therefore raises a data-ready flag. The flag sets after an idle period of fifteen bit times, counted from the most recent end-of-stop-bit pulse. That period is one and a half frames of an 8-data-bit, 1-stop-bit character.

Software clears the flag with a handshake. It first reads the flag while it is 1, then writes 0 once the queue is empty. A DMA read that removes the last byte also clears the flag. In clocked synchronous mode the flag never sets.

Top module: `rx_fifo_idle_flag`

## Requirements
- R1: Bytes written with `rx_wr` leave in arrival order on `rd_data`, which always shows the oldest entry. `fifo_count` tracks the number of entries. A write when 16 entries are held is dropped. A pop when empty does nothing. `cpu_rd` and `dma_rd` both pop, and asserting both in one cycle removes only one entry.
- R2: `full_req` is high exactly while `fifo_count` is at or above the trigger level. The `trig_sel` encoding is 0 → 1, 1 → 4, 2 → 8, 3 → 14.
- R3: With `sync_mode` = 0, the flag rises at the clock edge that takes the 15th `bit_tick` after an `stop_end` pulse, provided that the FIFO holds at least one and fewer than trigger-level entries at that moment. It is still 0 after the 14th tick.
- R4: The idle count restarts on every `stop_end` pulse and fires only once per pulse. After it fires, further ticks cannot set the flag until the next `stop_end`.
- R5: While `sync_mode` = 1 the flag never sets.
- R6: Reset leaves the flag at 0, `fifo_count` at 0 and `full_req` at 0.
- R7: A `flag_rd` while the flag is 1 arms the clear. The next `flag_wr` consumes the arming. That write clears the flag only if `flag_wdata` = 0 and the FIFO is empty. A write of 0 without arming has no effect.
- R8: A `flag_wr` with `flag_wdata` = 1 never sets the flag.
- R9: A `dma_rd` that removes the last entry clears the flag at that edge.
- R10: A new set event between the arming read and the write cancels the arming, so that write leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_wr | input | 1 | Received-byte write strobe |
| rx_byte | input | DATA_W (8) | Received byte |
| stop_end | input | 1 | End-of-stop-bit pulse |
| bit_tick | input | 1 | One pulse per bit time |
| trig_sel | input | 2 | Trigger level select |
| sync_mode | input | 1 | 1 = clocked synchronous mode |
| cpu_rd | input | 1 | CPU data read (pop) |
| dma_rd | input | 1 | DMA data read (pop) |
| flag_rd | input | 1 | CPU status read access |
| flag_wr | input | 1 | CPU status write access |
| flag_wdata | input | 1 | Value written to the flag |
| rd_data | output | DATA_W (8) | Oldest FIFO entry |
| fifo_count | output | $clog2(DEPTH+1) (5) | Entries held |
| data_ready | output | 1 | Idle-timeout data-ready flag |
| full_req | output | 1 | Fill level at or above trigger |

## Verification
The bench sweeps every trigger setting against every fill level from empty to overfull. Each pass checks the count, the trigger request and the flag both one tick before and at the timeout. A design with an off-by-one idle count, one that lets an empty FIFO time out, or one that compares with the wrong sense against the trigger would fail here.

The handshake is probed in its awkward orders: an unarmed write, an armed write with data still present, and a timeout landing between the read and the write. A design that clears too eagerly would drop the flag in one of these cases.

Timer restart and hold are tested with stop pulses mid-count and with long idle stretches after a firing. A free-running counter would set the flag a second time in these runs.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int LVL_W = 8;

   // Trigger level decode for the two-bit select
   function automatic logic [LVL_W-1:0] trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8'd1;
         2'd1:    return 8'd4;
         2'd2:    return 8'd8;
         default: return 8'd14;
      endcase
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DATA_W-1:0]          din,
   input  logic                       pop,
   output logic [DATA_W-1:0]          dout,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("rxq_store: DEPTH must be a power of two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_store: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              push_ok, pop_ok;

   assign push_ok = push && (count != CW'(DEPTH));
   assign pop_ok  = pop && (count != '0);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH) && push && !pop) |=> count == CW'(DEPTH));
   assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push) |=> count == '0);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int IDLE_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_end,
   input  logic tick,
   output logic fire
);
   localparam int TW = $clog2(IDLE_BITS+1);

   if (IDLE_BITS < 2) begin : g_bad_idle
      $error("rxq_idle_timer: IDLE_BITS must be at least 2");
   end

   logic [TW-1:0] cnt;
   logic          running;

   assign fire = running && tick && !stop_end && (cnt == TW'(IDLE_BITS-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (stop_end) begin
         cnt     <= '0;
         running <= 1'b1;
      end else if (running && tick) begin
         cnt <= cnt + 1'b1;
         if (cnt == TW'(IDLE_BITS-1)) running <= 1'b0;
      end
   end

   assert_fire_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   assert_hold_after_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !stop_end) |=> !running);
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TW'(IDLE_BITS));
endmodule

// File: rtl/rxq_ready_flag.sv
module rxq_ready_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic sync_mode,
   input  logic starved,
   input  logic drained,
   input  logic dma_last,
   input  logic flag_rd,
   input  logic flag_wr,
   input  logic flag_wdata,
   output logic ready
);
   logic armed, set_ev, clr_sw;

   assign set_ev = fire && !sync_mode && starved;
   assign clr_sw = flag_wr && !flag_wdata && armed && drained;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (set_ev)                  ready <= 1'b1;
         else if (clr_sw || dma_last) ready <= 1'b0;

         if (set_ev || flag_wr || dma_last) armed <= 1'b0;
         else if (flag_rd && ready)         armed <= 1'b1;
      end
   end

   assert_sync_never_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !ready) |=> !ready);
   assert_write_one_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && flag_wdata && !ready && !fire) |=> !ready);
   assert_unarmed_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && flag_wr && !armed && !dma_last) |=> ready);
   assert_rise_needs_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(fire));
endmodule

// File: rtl/rx_fifo_idle_flag.sv
module rx_fifo_idle_flag #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int IDLE_BITS = 15
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rx_wr,
   input  logic [DATA_W-1:0]          rx_byte,
   input  logic                       stop_end,
   input  logic                       bit_tick,
   input  logic [1:0]                 trig_sel,
   input  logic                       sync_mode,
   input  logic                       cpu_rd,
   input  logic                       dma_rd,
   input  logic                       flag_rd,
   input  logic                       flag_wr,
   input  logic                       flag_wdata,
   output logic [DATA_W-1:0]          rd_data,
   output logic [$clog2(DEPTH+1)-1:0] fifo_count,
   output logic                       data_ready,
   output logic                       full_req
);
   import rxq_pkg::*;

   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 14) begin : g_bad_depth
      $error("rx_fifo_idle_flag: DEPTH must hold the largest trigger level");
   end

   logic [CW-1:0] lvl;
   logic          fire, starved, dma_last;

   assign lvl      = CW'(trig_level(trig_sel));
   assign full_req = (fifo_count >= lvl);
   assign starved  = (fifo_count != '0) && (fifo_count < lvl);
   assign dma_last = dma_rd && !rx_wr && (fifo_count == CW'(1));

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_wr),
      .din   (rx_byte),
      .pop   (cpu_rd | dma_rd),
      .dout  (rd_data),
      .count (fifo_count)
   );

   rxq_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_end (stop_end),
      .tick     (bit_tick),
      .fire     (fire)
   );

   rxq_ready_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .sync_mode  (sync_mode),
      .starved    (starved),
      .drained    (fifo_count == '0),
      .dma_last   (dma_last),
      .flag_rd    (flag_rd),
      .flag_wr    (flag_wr),
      .flag_wdata (flag_wdata),
      .ready      (data_ready)
   );

   assert_dma_drain_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_last && !fire) |=> !data_ready);
   assert_fall_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready) |-> ($past(fifo_count) == '0 || $past(dma_rd)));
endmodule

// File: tb/rx_fifo_idle_flag_test.sv
module rx_fifo_idle_flag_test;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_wr = 1'b0, stop_end = 1'b0, bit_tick = 1'b0, sync_mode = 1'b0;
   logic       cpu_rd = 1'b0, dma_rd = 1'b0, flag_rd = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
   logic [7:0] rx_byte = '0;
   logic [1:0] trig_sel = '0;
   logic [7:0] rd_data;
   logic [4:0] fifo_count;
   logic       data_ready, full_req;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   rx_fifo_idle_flag uut (
      .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_byte(rx_byte),
      .stop_end(stop_end), .bit_tick(bit_tick), .trig_sel(trig_sel),
      .sync_mode(sync_mode), .cpu_rd(cpu_rd), .dma_rd(dma_rd),
      .flag_rd(flag_rd), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .rd_data(rd_data), .fifo_count(fifo_count), .data_ready(data_ready),
      .full_req(full_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push(input logic [7:0] v);
      rx_wr = 1'b1; rx_byte = v; @(negedge clk); rx_wr = 1'b0;
   endtask

   task automatic stop_pulse();
      stop_end = 1'b1; @(negedge clk); stop_end = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic pop(input bit use_cpu, input bit use_dma);
      cpu_rd = use_cpu; dma_rd = use_dma; @(negedge clk); cpu_rd = 1'b0; dma_rd = 1'b0;
   endtask

   task automatic sread();
      flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
   endtask

   task automatic swrite(input bit v);
      flag_wr = 1'b1; flag_wdata = v; @(negedge clk); flag_wr = 1'b0; flag_wdata = 1'b0;
   endtask

   task automatic arm_one();
      push(8'hA5); stop_pulse(); ticks(15);
   endtask

   function automatic int lvl_of(input int s);
      return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      chk("R6 flag", data_ready, 0);
      chk("R6 count", fifo_count, 0);
      chk("R6 full_req", full_req, 0);

      // Sweep: every trigger setting against every fill level
      for (int s = 0; s < 4; s++) begin
         for (int n = 0; n <= 16; n++) begin
            int lv;
            int expf;
            lv = lvl_of(s);
            expf = (n > 0 && n < lv) ? 1 : 0;
            trig_sel = 2'(s);
            do_reset();
            for (int k = 0; k < n; k++) push(8'((s * 37 + n * 5 + k) & 255));
            if (n == 16) push(8'hFF);
            chk("R1 count", fifo_count, n);
            chk("R2 full_req", full_req, (n >= lv) ? 1 : 0);
            stop_pulse();
            ticks(14);
            chk("R3 flag after 14 ticks", data_ready, 0);
            ticks(1);
            chk("R3 flag after 15 ticks", data_ready, expf);
            for (int k = 0; k < n; k++) begin
               chk("R1 order", rd_data, (s * 37 + n * 5 + k) & 255);
               pop(s[0] == 1'b0, s[0] == 1'b1);
            end
            chk("R1 drained", fifo_count, 0);
            if (s[0] == 1'b1) begin
               chk("R9 dma drain clears", data_ready, 0);
            end else if (expf == 1) begin
               swrite(1'b0);
               chk("R7 unarmed write ignored", data_ready, 1);
               sread();
               swrite(1'b0);
               chk("R7 armed write clears", data_ready, 0);
            end
         end
      end

      // R1: empty pop, and a dual pop removing one entry
      trig_sel = 2'd3;
      do_reset();
      pop(1'b1, 1'b0);
      chk("R1 empty pop", fifo_count, 0);
      push(8'h11); push(8'h22);
      pop(1'b1, 1'b1);
      chk("R1 dual pop count", fifo_count, 1);
      chk("R1 dual pop data", rd_data, 8'h22);

      // R5: synchronous mode never sets
      do_reset();
      sync_mode = 1'b1;
      arm_one();
      ticks(5);
      chk("R5 sync mode", data_ready, 0);
      sync_mode = 1'b0;

      // R8: writing 1 never sets
      do_reset();
      push(8'h01);
      swrite(1'b1);
      chk("R8 write one", data_ready, 0);

      // R4: hold after firing, then restart
      do_reset();
      arm_one();
      chk("R4 first fire", data_ready, 1);
      sread(); pop(1'b1, 1'b0); swrite(1'b0);
      chk("R7 clear", data_ready, 0);
      push(8'h33);
      ticks(20);
      chk("R4 held after fire", data_ready, 0);
      stop_pulse(); ticks(10); stop_pulse(); ticks(10);
      chk("R4 restart mid count", data_ready, 0);
      ticks(5);
      chk("R4 fires after restart", data_ready, 1);

      // R7: armed write with data present, then arming consumed
      do_reset();
      arm_one();
      sread();
      swrite(1'b0);
      chk("R7 not empty keeps flag", data_ready, 1);
      pop(1'b1, 1'b0);
      swrite(1'b0);
      chk("R7 arming consumed", data_ready, 1);
      sread(); swrite(1'b0);
      chk("R7 rearm clears", data_ready, 0);

      // R10: new set event between read and write cancels arming
      do_reset();
      arm_one();
      sread();
      pop(1'b1, 1'b0);
      arm_one();
      pop(1'b1, 1'b0);
      swrite(1'b0);
      chk("R10 new set cancels arming", data_ready, 1);
      sread(); swrite(1'b0);
      chk("R10 second handshake clears", data_ready, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule